// File: doc/BRIEF.md
# Double-Buffered SPI Configuration Port

This block is an SPI target that gives a host access to a small byte-wide register file. The host begins each transaction with a 16-bit instruction that gives the direction, the transfer length and a start address. Data bytes follow. During a multi-byte transfer the address steps automatically after each byte.

A configuration byte at address 0x000 sets the port's behaviour. One field chooses 3-wire or 4-wire signalling. A single bit sets both the serial bit order and the direction in which the address steps. Writing a third bit with a value of 1 causes a self-clearing soft reset. When the configuration byte is read back, its low nibble is the high nibble bit-reversed, so the byte reads the same in either bit order.

Device registers are double buffered. A serial write changes only the buffered copy. A pulse on `io_update_i` copies every buffered register into its active copy at the same time, and the active copies drive the rest of the chip. A select bit at address 0x004 picks whether reads return the active copy or the buffered copy.

Top module: `spi_cfg_port`

## Requirements
- R1: A transaction starts when `csb_i` falls. The first 16 bits form the instruction: bit 15 is 1 for a read and 0 for a write, bits 14:13 give the length (00 = 1 byte, 01 = 2, 10 = 3, 11 = stream until `csb_i` rises), and bits 12:0 give the start address. The instruction uses the bit order currently selected.
- R2: Configuration bit 6 = 0 (the default) sends each word MSB first. The address decrements by one after each byte and wraps modulo 2^13.
- R3: Configuration bit 6 = 1 sends each word LSB first. The address increments by one after each byte.
- R4: A write to 0x000 is decoded from bits 7:4 only, and bits 3:0 are ignored. It takes effect at the byte boundary, so later bytes of the same transfer use the new bit order. The address step that follows that byte still uses the previous direction. A read of 0x000 returns {b7, b6, 0, 0, 0, 0, b6, b7}.
- R5: With configuration bit 7 = 0 (3-wire, the default), read data bits come out on `sdio_o` with `sdio_oe_o` high, and `sdo_oe_o` stays low.
- R6: With configuration bit 7 = 1 (4-wire), read data bits come out on `sdo_o` with `sdo_oe_o` high, and `sdio_oe_o` stays low.
- R7: Writing 0x000 with bit 5 = 1 restores every register to its default: configuration 0x00, readback select 0, user ID 0x0000 and device registers `DEV_RST`. Bit 5 always reads back as 0.
- R8: Writes to the user ID (0x005 low byte, 0x006 high byte) and to the device registers (`DEV_BASE` onward) land in the buffer. The active copies, which appear on `act_regs_o` with register `DEV_BASE` in the low byte, change only when `io_update_i` rises. At that point all of them are loaded at once.
- R9: Address 0x004 bit 0 selects the readback source for buffered registers: 0 returns the active value and 1 returns the buffered value. A read of 0x004 returns {7'b0, select}.
- R10: A read of an unimplemented address returns 0x00, and a write to one has no effect.
- R11: A rising `csb_i` ends the transaction. A partially shifted byte is discarded, and the next transaction starts with a fresh instruction.
- R12: In a fixed-length transfer, clock cycles beyond the stated byte count write nothing and drive no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock; data sampled on rising edge |
| csb_i | input | 1 | Chip select, active low |
| sdio_i | input | 1 | Serial data in (shared pin, input side) |
| io_update_i | input | 1 | Update strobe, asynchronous, acts on rising edge |
| sdio_o | output | 1 | Read data in 3-wire mode |
| sdio_oe_o | output | 1 | Output enable for the shared pin |
| sdo_o | output | 1 | Read data in 4-wire mode |
| sdo_oe_o | output | 1 | Output enable for the dedicated output pin |
| act_regs_o | output | NUM_DEV*8 | Active device registers |

## Verification
The bench changes the configuration in the middle of a streamed write. It steps down from 0x004 to 0x000, wraps to 0x1FFF, and then writes 0x000 again in the new bit order. A design that applied the new order late, or stepped the address in the new direction, would write the wrong location or read back a bit-reversed configuration. Reads in both wire modes check which enable is driven, so swapped pins show up at once. Random traffic interleaves update strobes and readback-select changes. A design that let writes reach the active copy, or updated registers one at a time, would mismatch on `act_regs_o` or on buffered reads. Aborted bytes, overlong fixed transfers, unimplemented addresses and soft reset are each driven directly. A design that committed a partial byte, kept writing past the count, or missed a default would fail on those reads.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W = 13;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_e;

  localparam addr_t CFG_ADDR   = 13'h000;
  localparam addr_t RBSEL_ADDR = 13'h004;
  localparam addr_t UID_LO     = 13'h005;
  localparam addr_t UID_HI     = 13'h006;

  localparam int CFG_SDO_BIT  = 7;
  localparam int CFG_LSB_BIT  = 6;
  localparam int CFG_SRST_BIT = 5;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter
  import spi_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       csb_i,
  input  logic       sdi_i,
  input  logic       lsb_first_i,
  input  logic       sdo_active_i,
  input  logic [7:0] rdata_i,
  output addr_t      raddr_o,
  output logic       wr_o,
  output addr_t      waddr_o,
  output logic [7:0] wdata_o,
  output logic       sdio_o,
  output logic       sdio_oe_o,
  output logic       sdo_o,
  output logic       sdo_oe_o
);
  phase_e      phase_q;
  logic        sclk_d;
  logic [3:0]  bit_cnt_q;
  logic [1:0]  byte_cnt_q;
  logic [1:0]  len_q;
  logic        is_rd_q;
  logic [15:0] instr_q;
  logic [7:0]  rx_q;
  addr_t       addr_q;
  logic        wr_q;
  addr_t       waddr_q;
  logic [7:0]  wdata_q;

  logic        rise;
  logic [15:0] instr_nxt;
  logic [7:0]  rx_nxt;
  logic [2:0]  bit_sel;
  logic        rd_active;

  assign rise      = sclk_i & ~sclk_d;
  assign instr_nxt = lsb_first_i ? {sdi_i, instr_q[15:1]} : {instr_q[14:0], sdi_i};
  assign rx_nxt    = lsb_first_i ? {sdi_i, rx_q[7:1]} : {rx_q[6:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_INSTR;
      sclk_d     <= 1'b0;
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      len_q      <= '0;
      is_rd_q    <= 1'b0;
      instr_q    <= '0;
      rx_q       <= '0;
      addr_q     <= '0;
      wr_q       <= 1'b0;
      waddr_q    <= '0;
      wdata_q    <= '0;
    end else begin
      sclk_d <= sclk_i;
      wr_q   <= 1'b0;
      if (csb_i) begin
        phase_q    <= PH_INSTR;
        bit_cnt_q  <= '0;
        byte_cnt_q <= '0;
      end else if (rise) begin
        case (phase_q)
          PH_INSTR: begin
            instr_q <= instr_nxt;
            if (bit_cnt_q == 4'd15) begin
              is_rd_q    <= instr_nxt[15];
              len_q      <= instr_nxt[14:13];
              addr_q     <= instr_nxt[12:0];
              phase_q    <= PH_DATA;
              bit_cnt_q  <= '0;
              byte_cnt_q <= '0;
            end else begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
          PH_DATA: begin
            rx_q <= rx_nxt;
            if (bit_cnt_q == 4'd7) begin
              bit_cnt_q <= '0;
              if (!is_rd_q) begin
                wr_q    <= 1'b1;
                waddr_q <= addr_q;
                wdata_q <= rx_nxt;
              end
              // step uses the order in force for this byte
              addr_q <= lsb_first_i ? addr_q + addr_t'(1) : addr_q - addr_t'(1);
              if (len_q != 2'd3 && byte_cnt_q == len_q) phase_q <= PH_DONE;
              else byte_cnt_q <= byte_cnt_q + 2'd1;
            end else begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign bit_sel   = lsb_first_i ? bit_cnt_q[2:0] : 3'd7 - bit_cnt_q[2:0];
  assign rd_active = (phase_q == PH_DATA) && is_rd_q && !csb_i;
  assign raddr_o   = addr_q;
  assign wr_o      = wr_q;
  assign waddr_o   = waddr_q;
  assign wdata_o   = wdata_q;
  assign sdio_o    = rd_active & ~sdo_active_i & rdata_i[bit_sel];
  assign sdo_o     = rd_active &  sdo_active_i & rdata_i[bit_sel];
  assign sdio_oe_o = rd_active & ~sdo_active_i;
  assign sdo_oe_o  = rd_active &  sdo_active_i;

  // R11
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csb_i |=> (phase_q == PH_INSTR) && (bit_cnt_q == 4'd0));

  // R12
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DONE) |=> !wr_q);

  // R1
  wr_in_txn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> $past(phase_q == PH_DATA) && !$past(is_rd_q));
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int         NUM_DEV  = 4,
  parameter addr_t      DEV_BASE = 13'h010,
  parameter logic [7:0] DEV_RST  = 8'hA5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  addr_t                waddr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 upd_i,
  input  addr_t                raddr_i,
  output logic [7:0]           rdata_o,
  output logic                 lsb_first_o,
  output logic                 sdo_active_o,
  output logic [NUM_DEV*8-1:0] act_o
);
  localparam int    BUF_CNT = NUM_DEV + 2;
  localparam int    IDX_W   = $clog2(BUF_CNT);
  localparam addr_t DEV_END = addr_t'(DEV_BASE + addr_t'(NUM_DEV));

  function automatic logic [IDX_W:0] map_addr(input addr_t a);
    if (a == UID_LO) return {1'b1, IDX_W'(0)};
    if (a == UID_HI) return {1'b1, IDX_W'(1)};
    if (a >= DEV_BASE && a < DEV_END) return {1'b1, IDX_W'(a - DEV_BASE) + IDX_W'(2)};
    return '0;
  endfunction

  logic             cfg_sdo_q, cfg_lsb_q, rb_sel_q;
  logic [7:0]       buf_q [BUF_CNT];
  logic [7:0]       act_q [BUF_CNT];
  logic [BUF_CNT*8-1:0] buf_flat, act_flat;
  logic [IDX_W:0]   wmap, rmap;
  logic             srst;

  assign wmap = map_addr(waddr_i);
  assign rmap = map_addr(raddr_i);
  assign srst = wr_i && (waddr_i == CFG_ADDR) && wdata_i[CFG_SRST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_sdo_q <= 1'b0;
      cfg_lsb_q <= 1'b0;
      rb_sel_q  <= 1'b0;
    end else if (srst) begin
      cfg_sdo_q <= 1'b0;
      cfg_lsb_q <= 1'b0;
      rb_sel_q  <= 1'b0;
    end else if (wr_i && waddr_i == CFG_ADDR) begin
      cfg_sdo_q <= wdata_i[CFG_SDO_BIT];
      cfg_lsb_q <= wdata_i[CFG_LSB_BIT];
    end else if (wr_i && waddr_i == RBSEL_ADDR) begin
      rb_sel_q <= wdata_i[0];
    end
  end

  for (genvar g = 0; g < BUF_CNT; g++) begin : g_ent
    localparam logic [7:0] DFLT = (g < 2) ? 8'h00 : DEV_RST;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q[g] <= DFLT;
        act_q[g] <= DFLT;
      end else if (srst) begin
        buf_q[g] <= DFLT;
        act_q[g] <= DFLT;
      end else begin
        if (wr_i && wmap[IDX_W] && wmap[IDX_W-1:0] == IDX_W'(g)) buf_q[g] <= wdata_i;
        if (upd_i) act_q[g] <= buf_q[g];
      end
    end
    assign buf_flat[g*8 +: 8] = buf_q[g];
    assign act_flat[g*8 +: 8] = act_q[g];
  end

  always_comb begin
    rdata_o = 8'h00;
    if (raddr_i == CFG_ADDR)
      rdata_o = {cfg_sdo_q, cfg_lsb_q, 4'b0000, cfg_lsb_q, cfg_sdo_q};
    else if (raddr_i == RBSEL_ADDR)
      rdata_o = {7'b0, rb_sel_q};
    else if (rmap[IDX_W])
      rdata_o = rb_sel_q ? buf_flat[rmap[IDX_W-1:0]*8 +: 8] : act_flat[rmap[IDX_W-1:0]*8 +: 8];
  end

  assign lsb_first_o  = cfg_lsb_q;
  assign sdo_active_o = cfg_sdo_q;
  assign act_o        = act_flat[BUF_CNT*8-1:16];

  // R8
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !srst) |=> $stable(act_flat));

  // R7
  srst_dflt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> !cfg_sdo_q && !cfg_lsb_q && !rb_sel_q);

  // R10
  unimp_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wmap[IDX_W] && waddr_i != CFG_ADDR && waddr_i != RBSEL_ADDR && !upd_i)
      |=> $stable(buf_flat) && $stable(act_flat));
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int         NUM_DEV  = 4,
  parameter addr_t      DEV_BASE = 13'h010,
  parameter logic [7:0] DEV_RST  = 8'hA5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 csb_i,
  input  logic                 sdio_i,
  input  logic                 io_update_i,
  output logic                 sdio_o,
  output logic                 sdio_oe_o,
  output logic                 sdo_o,
  output logic                 sdo_oe_o,
  output logic [NUM_DEV*8-1:0] act_regs_o
);
  logic [2:0] spi_s;
  logic       upd_s, upd_d, upd_pulse;
  logic       lsb_first, sdo_active, wr;
  addr_t      raddr, waddr;
  logic [7:0] rdata, wdata;

  spi_cfg_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync_spi (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .d_i   ({sclk_i, csb_i, sdio_i}), .q_o (spi_s)
  );

  spi_cfg_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_sync_upd (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (io_update_i), .q_o (upd_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_d <= 1'b0;
    else         upd_d <= upd_s;
  end
  assign upd_pulse = upd_s & ~upd_d;

  spi_cfg_shifter u_shifter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_i       (spi_s[2]),
    .csb_i        (spi_s[1]),
    .sdi_i        (spi_s[0]),
    .lsb_first_i  (lsb_first),
    .sdo_active_i (sdo_active),
    .rdata_i      (rdata),
    .raddr_o      (raddr),
    .wr_o         (wr),
    .waddr_o      (waddr),
    .wdata_o      (wdata),
    .sdio_o       (sdio_o),
    .sdio_oe_o    (sdio_oe_o),
    .sdo_o        (sdo_o),
    .sdo_oe_o     (sdo_oe_o)
  );

  spi_cfg_regs #(.NUM_DEV(NUM_DEV), .DEV_BASE(DEV_BASE), .DEV_RST(DEV_RST)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr),
    .waddr_i      (waddr),
    .wdata_i      (wdata),
    .upd_i        (upd_pulse),
    .raddr_i      (raddr),
    .rdata_o      (rdata),
    .lsb_first_o  (lsb_first),
    .sdo_active_o (sdo_active),
    .act_o        (act_regs_o)
  );

  // R5
  oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdio_oe_o && sdo_oe_o));
endmodule

// File: tb/spi_cfg_port_bench.sv
module spi_cfg_port_bench;
  localparam int         NUM_DEV  = 4;
  localparam logic [12:0] DEV_BASE = 13'h010;
  localparam logic [7:0] DEV_RST  = 8'hA5;
  localparam int         HALF     = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sclk_i = 1'b0, csb_i = 1'b1, sdio_i = 1'b0, io_update_i = 1'b0;
  logic sdio_o, sdio_oe_o, sdo_o, sdo_oe_o;
  logic [NUM_DEV*8-1:0] act_regs_o;

  always #4 clk_i = ~clk_i;

  spi_cfg_port #(.NUM_DEV(NUM_DEV), .DEV_BASE(DEV_BASE), .DEV_RST(DEV_RST)) u_spi_cfg_port (
    .clk_i, .rst_ni, .sclk_i, .csb_i, .sdio_i, .io_update_i,
    .sdio_o, .sdio_oe_o, .sdo_o, .sdo_oe_o, .act_regs_o
  );

  int n_chk = 0, n_fail = 0;
  logic m_sdo, m_lsb, m_rb;
  logic [7:0] m_buf [NUM_DEV+2];
  logic [7:0] m_act [NUM_DEV+2];
  logic [7:0] tx_buf [8];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bidx(input logic [12:0] a);
    if (a == 13'h005) return 0;
    if (a == 13'h006) return 1;
    if (a >= DEV_BASE && a < DEV_BASE + 13'(NUM_DEV)) return int'(a - DEV_BASE) + 2;
    return -1;
  endfunction

  task automatic m_defaults();
    m_sdo = 0; m_lsb = 0; m_rb = 0;
    for (int i = 0; i < NUM_DEV + 2; i++) begin
      m_buf[i] = (i < 2) ? 8'h00 : DEV_RST;
      m_act[i] = m_buf[i];
    end
  endtask

  function automatic logic [7:0] m_rd(input logic [12:0] a);
    int k;
    k = bidx(a);
    if (a == 13'h000) return {m_sdo, m_lsb, 4'b0000, m_lsb, m_sdo};
    if (a == 13'h004) return {7'b0, m_rb};
    if (k >= 0) return m_rb ? m_buf[k] : m_act[k];
    return 8'h00;
  endfunction

  task automatic m_wr(input logic [12:0] a, input logic [7:0] d);
    int k;
    k = bidx(a);
    if (a == 13'h000) begin
      if (d[5]) m_defaults();
      else begin m_sdo = d[7]; m_lsb = d[6]; end
    end else if (a == 13'h004) m_rb = d[0];
    else if (k >= 0) m_buf[k] = d;
  endtask

  function automatic logic [31:0] m_act_vec();
    logic [31:0] v;
    for (int i = 0; i < NUM_DEV; i++) v[i*8 +: 8] = m_act[i+2];
    return v;
  endfunction

  task automatic spi_bit(input logic d, output logic q, output logic oe_a, output logic oe_b);
    sdio_i = d;
    repeat (HALF) @(negedge clk_i);
    q = m_sdo ? sdo_o : sdio_o;
    oe_a = sdio_oe_o; oe_b = sdo_oe_o;
    sclk_i = 1'b1;
    repeat (HALF) @(negedge clk_i);
    sclk_i = 1'b0;
  endtask

  task automatic xfer(input logic rd, input logic [1:0] len, input logic [12:0] addr,
                      input int nbytes, input string tag);
    logic [15:0] ins;
    logic q, oa, ob, lsb_now;
    logic [12:0] a;
    logic [7:0] got, exp;
    int limit;
    ins = {rd, len, addr};
    a = addr;
    limit = (len == 2'd3) ? 1000 : int'(len) + 1;
    @(negedge clk_i); csb_i = 1'b0;
    repeat (4) @(negedge clk_i);
    for (int i = 0; i < 16; i++) spi_bit(m_lsb ? ins[i] : ins[15-i], q, oa, ob);
    for (int k = 0; k < nbytes; k++) begin
      lsb_now = m_lsb;
      exp = m_rd(a);
      got = 8'h00;
      for (int i = 0; i < 8; i++) begin
        int p;
        p = lsb_now ? i : 7 - i;
        spi_bit(rd ? 1'b0 : tx_buf[k][p], q, oa, ob);
        got[p] = q;
        if (rd && i == 0) begin
          if (k < limit) begin
            if (m_sdo) chk({"R6 4-wire enables ", tag}, {oa, ob}, 2'b01);
            else       chk({"R5 3-wire enables ", tag}, {oa, ob}, 2'b10);
          end else chk({"R12 idle past length ", tag}, {oa, ob}, 2'b00);
        end
      end
      if (k < limit) begin
        if (rd) chk({"R1 read data ", tag}, got, exp);
        else m_wr(a, tx_buf[k]);
        a = lsb_now ? a + 13'd1 : a - 13'd1;
      end
    end
    repeat (4) @(negedge clk_i);
    csb_i = 1'b1;
    repeat (8) @(negedge clk_i);
  endtask

  task automatic pulse_update();
    @(negedge clk_i); io_update_i = 1'b1;
    repeat (3) @(negedge clk_i); io_update_i = 1'b0;
    repeat (6) @(negedge clk_i);
    for (int i = 0; i < NUM_DEV + 2; i++) m_act[i] = m_buf[i];
  endtask

  initial begin
    repeat (180000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic q, oa, ob;
    void'($urandom(32'd4242));
    m_defaults();
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);

    // reset state
    chk("R8 active defaults", act_regs_o, {NUM_DEV{DEV_RST}});
    chk("R5 idle enables", {sdio_oe_o, sdo_oe_o}, 2'b00);
    xfer(1, 2'd0, 13'h000, 1, "R2 cfg default");
    xfer(1, 2'd1, 13'h006, 2, "R9 user id default");

    // R2 streamed write stepping down 0x013..0x010
    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33; tx_buf[3] = 8'h44;
    xfer(0, 2'd3, 13'h013, 4, "R2 stream wr");
    chk("R8 active held", act_regs_o, m_act_vec());
    xfer(1, 2'd3, 13'h013, 4, "R9 active readback");
    tx_buf[0] = 8'h01;
    xfer(0, 2'd0, 13'h004, 1, "R9 sel buf");
    xfer(1, 2'd3, 13'h013, 4, "R9 buffered readback");
    xfer(1, 2'd0, 13'h004, 1, "R9 sel read");
    pulse_update();
    chk("R8 update copies all", act_regs_o, m_act_vec());

    // R10 unimplemented
    tx_buf[0] = 8'hFF; tx_buf[1] = 8'hEE;
    xfer(0, 2'd1, 13'h003, 2, "R10 wr unimpl");
    xfer(1, 2'd2, 13'h003, 3, "R10 rd unimpl");
    xfer(1, 2'd0, 13'h0FF, 1, "R10 rd far");

    // R3 LSB first, incrementing
    tx_buf[0] = 8'h42;
    xfer(0, 2'd0, 13'h000, 1, "R3 set lsb");
    xfer(1, 2'd0, 13'h000, 1, "R4 cfg mirror");
    tx_buf[0] = 8'hA1; tx_buf[1] = 8'hB2; tx_buf[2] = 8'hC3;
    xfer(0, 2'd2, 13'h010, 3, "R3 inc wr");
    xfer(1, 2'd2, 13'h010, 3, "R3 inc rd");
    xfer(1, 2'd1, 13'h005, 2, "R3 uid rd");

    // R4 order change mid-stream: back to MSB, step down through 0x000 and wrap
    tx_buf[0] = 8'h00;
    xfer(0, 2'd0, 13'h000, 1, "R4 back msb");
    tx_buf[0] = 8'h01; tx_buf[1] = 8'h0F; tx_buf[2] = 8'h0F; tx_buf[3] = 8'h0F;
    tx_buf[4] = 8'h42; tx_buf[5] = 8'h99; tx_buf[6] = 8'hC3;
    xfer(0, 2'd3, 13'h004, 7, "R4 mid-stream");
    xfer(1, 2'd0, 13'h000, 1, "R4 cfg after stream");
    xfer(1, 2'd1, 13'h010, 2, "R6 4-wire rd");

    // R7 soft reset (sent in current order)
    tx_buf[0] = 8'h24;
    xfer(0, 2'd0, 13'h000, 1, "R7 srst");
    repeat (4) @(negedge clk_i);
    chk("R7 active restored", act_regs_o, {NUM_DEV{DEV_RST}});
    xfer(1, 2'd0, 13'h000, 1, "R7 cfg cleared");
    xfer(1, 2'd0, 13'h004, 1, "R7 sel cleared");
    xfer(1, 2'd3, 13'h013, 4, "R7 regs restored");

    // R11 abort mid-byte
    tx_buf[0] = 8'h01;
    xfer(0, 2'd0, 13'h004, 1, "R11 sel buf");
    begin
      logic [15:0] ins;
      ins = {1'b0, 2'd0, 13'h012};
      @(negedge clk_i); csb_i = 1'b0;
      repeat (4) @(negedge clk_i);
      for (int i = 0; i < 16; i++) spi_bit(ins[15-i], q, oa, ob);
      for (int i = 0; i < 5; i++) spi_bit(1'b1, q, oa, ob);
      repeat (4) @(negedge clk_i); csb_i = 1'b1;
      repeat (8) @(negedge clk_i);
    end
    xfer(1, 2'd0, 13'h012, 1, "R11 partial dropped");

    // R12 extra bytes on fixed length
    tx_buf[0] = 8'h5A; tx_buf[1] = 8'h66; tx_buf[2] = 8'h77;
    xfer(0, 2'd0, 13'h011, 3, "R12 wr extra");
    xfer(1, 2'd1, 13'h011, 2, "R12 wr limited");
    xfer(1, 2'd0, 13'h011, 2, "R12 rd extra");

    // random traffic
    for (int it = 0; it < 45; it++) begin
      int op;
      logic [12:0] a;
      logic [1:0] ln;
      int nb;
      op = int'($urandom % 10);
      if (op < 6) begin
        case ($urandom % 6)
          0: a = 13'h004;
          1: a = 13'h005 + 13'($urandom % 2);
          2, 3: a = DEV_BASE + 13'($urandom % NUM_DEV);
          4: a = 13'($urandom % 32);
          default: a = 13'h000;
        endcase
        ln = 2'($urandom % 4);
        nb = (ln == 2'd3) ? 1 + int'($urandom % 4) : int'(ln) + 1 + int'($urandom % 2);
        for (int k = 0; k < 8; k++) begin
          tx_buf[k] = 8'($urandom);
          if ($urandom % 8 != 0) tx_buf[k][5] = 1'b0;
        end
        xfer(op < 3, ln, a, nb, "R1 random");
      end else if (op < 8) begin
        pulse_update();
        chk("R8 random update", act_regs_o, m_act_vec());
      end else if (op == 8) begin
        tx_buf[0] = 8'($urandom % 2);
        xfer(0, 2'd0, 13'h004, 1, "R9 random sel");
      end else begin
        tx_buf[0] = {2'($urandom), 2'b00, 4'b0000};
        tx_buf[0][1:0] = {tx_buf[0][6], tx_buf[0][7]};
        xfer(0, 2'd0, 13'h000, 1, "R4 random cfg");
        xfer(1, 2'd0, 13'h000, 1, "R4 random cfg rd");
      end
    end
    pulse_update();
    chk("R8 final active", act_regs_o, m_act_vec());

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule